// File: doc/BRIEF.md
# Vector Memory Address Generator

This block turns one vector load or store request into a stream of per-element memory addresses. A single sequencer covers four ways of forming the addresses: consecutive 64-bit words, a constant signed byte stride, an offset taken element by element from an index stream (the same path serves gathers and scatters), and an index-creation mode. The index-creation mode emits the multiples 0, m, 2m, and so on, which can later drive an indexed access.

A request is launched by a one-cycle start pulse, which carries the mode, base, stride and vector length. The block then presents one address per element on a valid/ready interface, together with the element number. Each address moves on only when the consumer accepts it. One cycle after the last element is accepted, a done pulse marks the end of the request. The memory, the data path and bank arbitration sit outside this block.

Top module: `vec_agen`

## Requirements
- R1: With mode_i = 0 (consecutive words), element i is presented at base_i + 8·i.
- R2: With mode_i = 1 (strided), element i is presented at base_i + i·stride_i, where stride_i is a signed two's-complement byte offset and the sum wraps modulo 2^ADDR_W.
- R3: With mode_i = 2 (indexed), element i is presented at base_i + idx_i. addr_valid_o follows idx_valid_i while a request is running. idx_ready_o is high only in a cycle in which the address is accepted, so exactly one index is used per element.
- R4: A request issues min(vl_i, 64) addresses, and elem_o counts 0, 1, ... up to that count minus one.
- R5: With mode_i = 3 (index creation), element i is presented at i·stride_i, and base_i is not used.
- R6: While addr_valid_o is high and addr_ready_i is low, addr_o, elem_o and addr_valid_o keep their values into the next cycle.
- R7: done_o is high for exactly one cycle: the cycle after the last address is accepted. addr_valid_o is low in that cycle.
- R8: A start with vl_i = 0 issues no address, and done_o is high in the cycle after the start.
- R9: A start_i that arrives while a request is running is ignored, and it causes neither a done pulse nor any change to the address stream.
- R10: After reset, addr_valid_o, idx_ready_o and done_o are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Launch pulse; accepted only when idle |
| mode_i | input | 2 | 0 words, 1 strided, 2 indexed, 3 index creation |
| base_i | input | ADDR_W | Base byte address |
| stride_i | input | ADDR_W | Signed byte stride, or multiplier in index creation |
| vl_i | input | VL_W | Requested vector length, clamped to MAX_VL |
| idx_valid_i | input | 1 | Index value available |
| idx_i | input | ADDR_W | Byte offset for the current element |
| idx_ready_o | output | 1 | Index consumed this cycle |
| addr_valid_o | output | 1 | Address available |
| addr_ready_i | input | 1 | Consumer accepts the address |
| addr_o | output | ADDR_W | Element byte address |
| elem_o | output | IDX_W | Element number of addr_o |
| done_o | output | 1 | One-cycle end-of-request pulse |

## Verification
In indexed mode the hold property assumes that the index source follows the usual valid/ready rule: once idx_valid_i is raised, idx_i stays stable and valid stays high until idx_ready_o takes the value. The stimulus keeps to this rule because it lowers idx_valid_i only while no value is pending. The property also assumes that mode, base and stride matter only in the start cycle. The stimulus changes them only alongside start pulses, and it issues a start during a running request only to test that the start is ignored.

// File: rtl/vec_agen_pkg.sv
package vec_agen_pkg;
  typedef enum logic [1:0] {
    AG_UNIT   = 2'd0,
    AG_STRIDE = 2'd1,
    AG_INDEX  = 2'd2,
    AG_IOTA   = 2'd3
  } ag_mode_e;
endpackage

// File: rtl/vec_agen_seq.sv
module vec_agen_seq #(
  parameter int MAX_VL = 64,
  parameter int VL_W   = 7,
  parameter int IDX_W  = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [VL_W-1:0]  vl_i,
  input  logic             fire_i,
  output logic             launch_o,
  output logic             busy_o,
  output logic [IDX_W-1:0] elem_o,
  output logic             done_o
);
  logic [VL_W-1:0]  vl_eff;
  logic [IDX_W-1:0] last_q;
  logic [IDX_W-1:0] cnt_q;
  logic             busy_q;
  logic             done_q;

  assign vl_eff   = (vl_i > VL_W'(MAX_VL)) ? VL_W'(MAX_VL) : vl_i;
  assign launch_o = start_i & ~busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      cnt_q  <= '0;
      last_q <= '0;
    end else begin
      done_q <= 1'b0;
      if (launch_o) begin
        cnt_q <= '0;
        if (vl_eff == '0) begin
          done_q <= 1'b1;
        end else begin
          busy_q <= 1'b1;
          last_q <= IDX_W'(vl_eff - VL_W'(1));
        end
      end else if (fire_i) begin
        if (cnt_q == last_q) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end else begin
          cnt_q <= cnt_q + IDX_W'(1);
        end
      end
    end
  end

  assign busy_o = busy_q;
  assign elem_o = cnt_q;
  assign done_o = done_q;
endmodule

// File: rtl/vec_agen_step.sv
module vec_agen_step
  import vec_agen_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int ELEM_BYTES = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              launch_i,
  input  ag_mode_e          mode_i,
  input  logic [ADDR_W-1:0] base_i,
  input  logic [ADDR_W-1:0] stride_i,
  input  logic              fire_i,
  output logic [ADDR_W-1:0] acc_o,
  output logic [ADDR_W-1:0] step_o
);
  logic [ADDR_W-1:0] acc_q;
  logic [ADDR_W-1:0] step_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q  <= '0;
      step_q <= '0;
    end else if (launch_i) begin
      acc_q  <= (mode_i == AG_IOTA) ? '0 : base_i;
      step_q <= (mode_i == AG_UNIT) ? ADDR_W'(ELEM_BYTES) : stride_i;
    end else if (fire_i) begin
      acc_q <= acc_q + step_q;  // wraps modulo 2^ADDR_W, negative strides included
    end
  end

  assign acc_o  = acc_q;
  assign step_o = step_q;
endmodule

// File: rtl/vec_agen_idx.sv
module vec_agen_idx #(
  parameter int ADDR_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              launch_i,
  input  logic [ADDR_W-1:0] base_i,
  input  logic [ADDR_W-1:0] idx_i,
  output logic [ADDR_W-1:0] addr_o
);
  logic [ADDR_W-1:0] base_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       base_q <= '0;
    else if (launch_i) base_q <= base_i;
  end

  assign addr_o = base_q + idx_i;
endmodule

// File: rtl/vec_agen.sv
module vec_agen
  import vec_agen_pkg::*;
#(
  parameter  int ADDR_W     = 32,
  parameter  int MAX_VL     = 64,
  parameter  int ELEM_BYTES = 8,
  localparam int VL_W       = $clog2(MAX_VL + 1),
  localparam int IDX_W      = $clog2(MAX_VL)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [1:0]        mode_i,
  input  logic [ADDR_W-1:0] base_i,
  input  logic [ADDR_W-1:0] stride_i,
  input  logic [VL_W-1:0]   vl_i,
  input  logic              idx_valid_i,
  input  logic [ADDR_W-1:0] idx_i,
  output logic              idx_ready_o,
  output logic              addr_valid_o,
  input  logic              addr_ready_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic [IDX_W-1:0]  elem_o,
  output logic              done_o
);
  ag_mode_e          mode_q;
  logic              launch;
  logic              busy;
  logic              fire;
  logic              indexed;
  logic [ADDR_W-1:0] acc;
  logic [ADDR_W-1:0] step;
  logic [ADDR_W-1:0] idx_addr;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     mode_q <= AG_UNIT;
    else if (launch) mode_q <= ag_mode_e'(mode_i);
  end

  assign indexed      = (mode_q == AG_INDEX);
  assign addr_valid_o = busy & (~indexed | idx_valid_i);
  assign idx_ready_o  = busy & indexed & idx_valid_i & addr_ready_i;
  assign fire         = addr_valid_o & addr_ready_i;
  assign addr_o       = indexed ? idx_addr : acc;

  vec_agen_seq #(
    .MAX_VL(MAX_VL),
    .VL_W  (VL_W),
    .IDX_W (IDX_W)
  ) u_seq (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start_i),
    .vl_i    (vl_i),
    .fire_i  (fire),
    .launch_o(launch),
    .busy_o  (busy),
    .elem_o  (elem_o),
    .done_o  (done_o)
  );

  vec_agen_step #(
    .ADDR_W    (ADDR_W),
    .ELEM_BYTES(ELEM_BYTES)
  ) u_step (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .launch_i(launch),
    .mode_i  (ag_mode_e'(mode_i)),
    .base_i  (base_i),
    .stride_i(stride_i),
    .fire_i  (fire),
    .acc_o   (acc),
    .step_o  (step)
  );

  vec_agen_idx #(
    .ADDR_W(ADDR_W)
  ) u_idx (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .launch_i(launch),
    .base_i  (base_i),
    .idx_i   (idx_i),
    .addr_o  (idx_addr)
  );
endmodule

// File: rtl/vec_agen_chk.sv
module vec_agen_chk #(
  parameter int ADDR_W     = 32,
  parameter int VL_W       = 7,
  parameter int IDX_W      = 6,
  parameter int ELEM_BYTES = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              start_i,
  input logic [VL_W-1:0]   vl_i,
  input logic              busy_i,
  input logic [1:0]        mode_q_i,
  input logic [ADDR_W-1:0] step_i,
  input logic              idx_ready_o,
  input logic              addr_valid_o,
  input logic              addr_ready_i,
  input logic [ADDR_W-1:0] addr_o,
  input logic [IDX_W-1:0]  elem_o,
  input logic              done_o
);
  p_unit_step_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    addr_valid_o && addr_ready_i && mode_q_i == 2'd0
    |=> done_o || addr_o == $past(addr_o) + ADDR_W'(ELEM_BYTES));

  p_stride_step_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    addr_valid_o && addr_ready_i && mode_q_i == 2'd1
    |=> done_o || addr_o == $past(addr_o) + $past(step_i));

  p_idx_take_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idx_ready_o |-> addr_valid_o && addr_ready_i);

  p_elem_next_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    addr_valid_o && addr_ready_i |=> done_o || elem_o == $past(elem_o) + IDX_W'(1));

  p_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    addr_valid_o && !addr_ready_i
    |=> addr_valid_o && $stable(addr_o) && $stable(elem_o));

  p_done_quiet_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !addr_valid_o);

  p_zero_len_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i && !busy_i && vl_i == '0 |=> done_o && !addr_valid_o);

  p_busy_start_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i && start_i |=> $stable(mode_q_i) && !done_o || $past(addr_valid_o && addr_ready_i));

  p_idle_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_i |-> !addr_valid_o && !idx_ready_o);
endmodule

bind vec_agen vec_agen_chk #(
  .ADDR_W    (ADDR_W),
  .VL_W      (VL_W),
  .IDX_W     (IDX_W),
  .ELEM_BYTES(ELEM_BYTES)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .start_i     (start_i),
  .vl_i        (vl_i),
  .busy_i      (busy),
  .mode_q_i    (mode_q),
  .step_i      (step),
  .idx_ready_o (idx_ready_o),
  .addr_valid_o(addr_valid_o),
  .addr_ready_i(addr_ready_i),
  .addr_o      (addr_o),
  .elem_o      (elem_o),
  .done_o      (done_o)
);

// File: tb/vec_agen_tb_top.sv
module vec_agen_tb_top;
  localparam int AW = 32;
  localparam int VW = 7;
  localparam int IW = 6;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start_i = 1'b0;
  logic [1:0]    mode_i = '0;
  logic [AW-1:0] base_i = '0;
  logic [AW-1:0] stride_i = '0;
  logic [VW-1:0] vl_i = '0;
  logic          idx_valid_i = 1'b0;
  logic [AW-1:0] idx_i = '0;
  logic          idx_ready_o;
  logic          addr_valid_o;
  logic          addr_ready_i = 1'b0;
  logic [AW-1:0] addr_o;
  logic [IW-1:0] elem_o;
  logic          done_o;

  always #2 clk = ~clk;

  vec_agen dut_i (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start_i), .mode_i(mode_i),
    .base_i(base_i), .stride_i(stride_i), .vl_i(vl_i),
    .idx_valid_i(idx_valid_i), .idx_i(idx_i), .idx_ready_o(idx_ready_o),
    .addr_valid_o(addr_valid_o), .addr_ready_i(addr_ready_i),
    .addr_o(addr_o), .elem_o(elem_o), .done_o(done_o)
  );

  typedef struct packed {
    logic [AW-1:0] a;
    logic [IW-1:0] e;
  } exp_t;

  exp_t          exp_q[$];
  logic [AW-1:0] idx_q[$];
  int            checks = 0;
  int            errors = 0;
  int            dones_seen = 0;
  bit            done_due = 0;
  bit            idx_pop = 0;
  bit            hold_pend = 0;
  bit            always_rdy = 1;
  logic [AW-1:0] held_a;
  logic [IW-1:0] held_e;
  string         cur_req = "R1";

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n) begin
      if (done_due) begin
        chk(done_o === 1'b1 && addr_valid_o === 1'b0, "R7", "done pulse", {63'd0, done_o}, 64'd1);
        done_due = 0;
        if (done_o) dones_seen++;
      end else if (done_o) begin
        chk(0, "R9", "unexpected done", 64'd1, 64'd0);
      end
      if (hold_pend) begin
        chk(addr_valid_o && addr_o == held_a && elem_o == held_e, "R6", "hold under stall",
            {32'd0, addr_o}, {32'd0, held_a});
        hold_pend = 0;
      end
      if (addr_valid_o && !addr_ready_i) begin
        hold_pend = 1;
        held_a = addr_o;
        held_e = elem_o;
      end
      if (idx_ready_o)
        chk(addr_valid_o && addr_ready_i, "R3", "index taken without accept", 64'd1, 64'd0);
      if (addr_valid_o && addr_ready_i) begin
        if (exp_q.size() == 0) begin
          chk(0, "R4", "extra address", {32'd0, addr_o}, 64'd0);
        end else begin
          exp_t e;
          e = exp_q.pop_front();
          chk(addr_o == e.a, cur_req, "address", {32'd0, addr_o}, {32'd0, e.a});
          chk(elem_o == e.e, "R4", "element number", {58'd0, elem_o}, {58'd0, e.e});
          if (exp_q.size() == 0) done_due = 1;
        end
      end
      if (idx_valid_i && idx_ready_o) idx_pop = 1;
    end
  end

  // index source and consumer ready
  always @(posedge clk) begin
    #1;
    if (idx_pop) begin
      void'(idx_q.pop_front());
      idx_pop = 0;
    end
    if (idx_q.size() == 0) idx_valid_i = 1'b0;
    else if (!idx_valid_i || idx_pop == 0) idx_valid_i = idx_valid_i || ($urandom % 4 != 0);
    idx_i = (idx_q.size() != 0) ? idx_q[0] : '0;
    addr_ready_i = always_rdy ? 1'b1 : ($urandom % 3 != 0);
  end

  task automatic run(input logic [1:0] m, input logic [AW-1:0] b, input logic [AW-1:0] s,
                     input int vl, input bit rdy, input bit poke_busy);
    int n;
    int target;
    n = (vl > 64) ? 64 : vl;
    always_rdy = rdy;
    case (m)
      2'd0: cur_req = "R1";
      2'd1: cur_req = "R2";
      2'd2: cur_req = "R3";
      default: cur_req = "R5";
    endcase
    for (int i = 0; i < n; i++) begin
      exp_t e;
      logic [AW-1:0] off;
      off = AW'(i * i * 8) - AW'(32);
      case (m)
        2'd0: e.a = b + AW'(i * 8);
        2'd1: e.a = b + AW'(i) * s;
        2'd2: begin e.a = b + off; idx_q.push_back(off); end
        default: e.a = AW'(i) * s;
      endcase
      e.e = IW'(i);
      exp_q.push_back(e);
    end
    target = dones_seen + 1;
    @(posedge clk); #1;
    start_i = 1'b1; mode_i = m; base_i = b; stride_i = s; vl_i = VW'(vl);
    @(posedge clk); #1;
    start_i = 1'b0;
    if (n == 0) done_due = 1;
    if (poke_busy) begin
      @(posedge clk); #1;
      start_i = 1'b1; mode_i = 2'd3; base_i = 32'h5555_0000; stride_i = 32'd1; vl_i = '0;
      @(posedge clk); #1;
      start_i = 1'b0;
    end
    wait (dones_seen >= target);
    chk(exp_q.size() == 0, "R4", "addresses left", exp_q.size(), 0);
    chk(idx_q.size() == 0, "R3", "indices left", idx_q.size(), 0);
    repeat (2) @(posedge clk);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk(!addr_valid_o && !idx_ready_o && !done_o, "R10", "reset outputs",
        {61'd0, addr_valid_o, idx_ready_o, done_o}, 64'd0);
    rst_n = 1'b1;
    repeat (2) @(posedge clk);
    run(2'd0, 32'h0000_1000, 32'd0, 5, 1, 0);             // R1
    run(2'd0, 32'h0000_2004, 32'd0, 12, 0, 0);            // R1 with stalls, R6
    run(2'd1, 32'h0000_2000, 32'd24, 7, 0, 0);            // R2
    run(2'd1, 32'h0000_3000, 32'hFFFF_FFF0, 6, 1, 0);     // R2 negative stride
    run(2'd1, 32'h0000_0010, 32'hFFFF_FFF8, 4, 1, 0);     // R2 wraps below zero
    run(2'd2, 32'h0000_8000, 32'd0, 9, 1, 0);             // R3
    run(2'd2, 32'h0001_0000, 32'd0, 15, 0, 0);            // R3 with stalls
    run(2'd3, 32'h0000_DEAD, 32'd5, 10, 1, 0);            // R5
    run(2'd0, 32'h0000_4000, 32'd0, 0, 1, 0);             // R8
    run(2'd0, 32'h0000_5000, 32'd0, 100, 0, 0);           // R4 clamp to 64
    run(2'd1, 32'h0000_6000, 32'd16, 20, 0, 1);           // R9 start while busy
    run(2'd1, 32'h0000_7000, 32'd40, 1, 1, 0);            // R4 single element
    run(2'd0, 32'h0000_9000, 32'd0, 64, 1, 0);            // R4 full length
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule